// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block is the control sequencer between a host controller and the contact set of a smart card reader. When the host opens a session, the block switches the card supply on, then the data lines, then the card clock, and finally lets the card reset follow the host. When the session closes it switches them off again in the reverse order. Every step is timed in half periods of a base period `T`, and `T` is `BASE_TICKS` pulses of an internal oscillator tick. The voltage regulation, the charge pump and the level shifters sit outside this block. It drives only their enables, plus a two-bit code for the requested card voltage.

The block also produces an active-low status line for the host. Outside a session this line shows debounced card presence. Inside a session it drops on any fault, and the block then shuts the contacts down by itself. When all three selection inputs are high while the interface is idle, the block enters a low-power stop state. In that state the status line simply follows the presence input. Leaving the stop state, or recovering supply, starts a power-up window during which host commands are ignored.

Top module: `cps_card_seq`

## Requirements
- R1: After reset, after supply-good returns, and on leaving the stop state, all contact enables are off and `status_n` is low for `PUP_TICKS` ticks; a session request in that window has no effect.
- R2: A session request (`sess_req_n` low, debounced card present, no pending fault) is taken at a clock edge t1. The supply enable rises at t1. The I/O enable rises at t1+4T. The card reset stays low until t1+7T.
- R3: If `host_rst` is low when the session is taken, the card clock starts on the cycle after the I/O enable rises.
- R4: If `host_rst` is high when the session is taken, the card clock waits. It starts on the cycle after `host_rst` is seen low once the I/O enable is up. If `host_rst` is still high at t1+7T, the clock starts at t1+7T.
- R5: From t1+7T on, `card_rst` copies `host_rst` with one cycle of delay.
- R6: Deactivation taken at edge t10 forces `card_rst` low at t10. The clock stops at t10+T/2, the I/O enable drops at t10+T, and the supply enable drops at t10+1.5T.
- R7: A session request made while deactivation is running is ignored. If it is still present when the block is idle again, activation starts on the next edge.
- R8: A fault flag during a session drives `status_n` low and runs the R6 order. `status_n` stays low, and no new session starts, until the host withdraws the request.
- R9: Loss of card presence during a session acts at once, without debounce, as a fault.
- R10: Outside a session, `status_n` rises only after `DEB_TICKS` consecutive ticks of presence, and it falls as soon as presence is lost.
- R11: `vcc_sel` reads 2'b00 while the supply is off. While the supply is on it holds the code captured at t1: 2'b11 when `sel_18` is high (this overrides `sel_5v`), otherwise 2'b10 for `sel_5v` high and 2'b01 for `sel_5v` low.
- R12: Idle with `sess_req_n`, `sel_18` and `sel_5v` all high enters the stop state. A running deactivation finishes first. In the stop state `status_n` follows `card_pres` directly. Any of the three inputs going low leaves the stop state through the R1 window and then the R10 debounce.
- R13: `supply_ok` low during a session is a fault. While idle, it holds the block in the power-up window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse of the internal timing oscillator |
| sess_req_n | input | 1 | Host session request, active low |
| host_rst | input | 1 | Host reset request for the card |
| sel_18 | input | 1 | Request for the 1.8 V card supply (overrides sel_5v) |
| sel_5v | input | 1 | High selects 5 V, low selects 3 V |
| card_pres | input | 1 | Card presence, active high |
| supply_ok | input | 1 | Host-side supply is above threshold |
| fault_in | input | NFAULT | Overcurrent, overtemperature and generator-range fault flags |
| vcc_en | output | 1 | Card supply generator enable |
| vcc_sel | output | 2 | Requested card voltage code |
| io_en | output | 1 | Data line enable |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset contact level |
| status_n | output | 1 | Active-low status and interrupt line to the host |

## Verification
The case that is hardest to reach from the ports is the clock hold window. There `host_rst` must be high at the exact edge the session is taken, stay high past the I/O enable, and then drop before t1+7T. A second session must run with `host_rst` held high throughout, to show the clock starting at t1+7T. The bench shortens `T` to eight ticks with a tick on every cycle, so every edge is a known cycle number. The driver then places the `host_rst` transitions, a request that comes back three cycles into a deactivation, and a stop entry issued in the middle of a live session at those computed cycles. A scoreboard requires every change of the output vector to land on its computed cycle and rejects any change it did not predict.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [2:0] {
        S_PUP   = 3'd0,
        S_IDLE  = 3'd1,
        S_ACT   = 3'd2,
        S_ON    = 3'd3,
        S_DEACT = 3'd4,
        S_STOP  = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        VS_OFF = 2'b00,
        VS_3V0 = 2'b01,
        VS_5V0 = 2'b10,
        VS_1V8 = 2'b11
    } vsel_e;

    typedef struct packed {
        logic vcc;
        logic io;
        logic clk;
        logic rst;
    } contact_t;

    // Step positions in half base periods.
    localparam int HC_W           = 4;
    localparam int ACT_IO_HALVES  = 8;   // 4T
    localparam int ACT_RST_HALVES = 14;  // 7T
    localparam int DE_CLK_HALVES  = 1;   // T/2
    localparam int DE_IO_HALVES   = 2;   // T
    localparam int DE_VCC_HALVES  = 3;   // 1.5T

    function automatic vsel_e pick_vsel(input logic want_18, input logic want_5);
        if (want_18)     return VS_1V8;
        else if (want_5) return VS_5V0;
        else             return VS_3V0;
    endfunction

endpackage

// File: rtl/cps_pres_filter.sv
module cps_pres_filter #(
    parameter int DEB_TICKS = 20480
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    input  logic pres_raw,
    output logic pres_ok
);
    localparam int CW = $clog2(DEB_TICKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !pres_raw) begin
            cnt     <= '0;
            pres_ok <= 1'b0;
        end else if (tick && !pres_ok) begin
            if (cnt == CW'(DEB_TICKS - 1)) pres_ok <= 1'b1;
            else                          cnt     <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cps_phase_timer.sv
module cps_phase_timer #(
    parameter int HALF_TICKS = 32,
    parameter int HW         = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          clear,
    output logic [HW-1:0] halves,
    output logic          half_done
);
    localparam int SW = $clog2(HALF_TICKS + 1);

    logic [SW-1:0] sub;

    assign half_done = tick && (sub == SW'(HALF_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sub    <= '0;
            halves <= '0;
        end else if (half_done) begin
            sub    <= '0;
            halves <= halves + 1'b1;
        end else if (tick) begin
            sub    <= sub + 1'b1;
        end
    end
endmodule

// File: rtl/cps_wait_timer.sv
module cps_wait_timer #(
    parameter int WAIT_TICKS = 563
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(WAIT_TICKS + 1);

    logic [CW-1:0] cnt;

    assign done = run && tick && (cnt == CW'(WAIT_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (done)    cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cps_card_seq.sv
module cps_card_seq
    import cps_pkg::*;
#(
    parameter int BASE_TICKS = 64,
    parameter int PUP_TICKS  = 563,
    parameter int DEB_TICKS  = 20480,
    parameter int NFAULT     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic              sess_req_n,
    input  logic              host_rst,
    input  logic              sel_18,
    input  logic              sel_5v,
    input  logic              card_pres,
    input  logic              supply_ok,
    input  logic [NFAULT-1:0] fault_in,
    output logic              vcc_en,
    output logic [1:0]        vcc_sel,
    output logic              io_en,
    output logic              clk_en,
    output logic              card_rst,
    output logic              status_n
);
    localparam int HALF_TICKS = BASE_TICKS / 2;

    seq_state_e      state;
    contact_t        con;
    vsel_e           vsel_q;
    logic            hold_clk;
    logic            fault_lat;
    logic [HC_W-1:0] halves;
    logic            half_done;
    logic            pup_done;
    logic            pres_ok;
    logic            fault_now;
    logic            stop_req;
    logic            start_ok;
    logic            go_act;
    logic            go_deact;

    assign fault_now = (|fault_in) || !supply_ok || !card_pres;
    assign stop_req  = sess_req_n && sel_18 && sel_5v;
    assign start_ok  = !sess_req_n && pres_ok && !fault_lat;
    assign go_act    = (state == S_IDLE) && supply_ok && start_ok;
    assign go_deact  = ((state == S_ACT) || (state == S_ON)) && (sess_req_n || fault_now);

    cps_phase_timer #(.HALF_TICKS(HALF_TICKS), .HW(HC_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .tick      (osc_tick),
        .clear     (go_act || go_deact),
        .halves    (halves),
        .half_done (half_done)
    );

    cps_wait_timer #(.WAIT_TICKS(PUP_TICKS)) u_pup (
        .clk  (clk),
        .rst  (rst),
        .tick (osc_tick),
        .run  ((state == S_PUP) && supply_ok),
        .done (pup_done)
    );

    cps_pres_filter #(.DEB_TICKS(DEB_TICKS)) u_pres (
        .clk      (clk),
        .rst      (rst),
        .tick     (osc_tick),
        .restart  (state == S_PUP),
        .pres_raw (card_pres),
        .pres_ok  (pres_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_PUP;
            con       <= '0;
            vsel_q    <= VS_OFF;
            hold_clk  <= 1'b0;
            fault_lat <= 1'b0;
        end else begin
            unique case (state)
                S_PUP: begin
                    fault_lat <= 1'b0;
                    if (pup_done) state <= S_IDLE;
                end
                S_IDLE: begin
                    if (!supply_ok) begin
                        state     <= S_PUP;
                        fault_lat <= 1'b0;
                    end else if (sess_req_n) begin
                        fault_lat <= 1'b0;
                        if (stop_req) state <= S_STOP;
                    end else if (go_act) begin
                        state    <= S_ACT;
                        con.vcc  <= 1'b1;
                        vsel_q   <= pick_vsel(sel_18, sel_5v);
                        hold_clk <= host_rst;
                    end
                end
                S_ACT: begin
                    if (go_deact) begin
                        state     <= S_DEACT;
                        fault_lat <= fault_now;
                        con.rst   <= 1'b0;
                    end else begin
                        if (half_done && halves == HC_W'(ACT_IO_HALVES - 1))
                            con.io <= 1'b1;
                        if (con.io && (!hold_clk || !host_rst))
                            con.clk <= 1'b1;
                        if (half_done && halves == HC_W'(ACT_RST_HALVES - 1)) begin
                            state   <= S_ON;
                            con.clk <= 1'b1;
                            con.rst <= host_rst;
                        end
                    end
                end
                S_ON: begin
                    if (go_deact) begin
                        state     <= S_DEACT;
                        fault_lat <= fault_now;
                        con.rst   <= 1'b0;
                    end else begin
                        con.rst <= host_rst;
                    end
                end
                S_DEACT: begin
                    if (half_done && halves == HC_W'(DE_CLK_HALVES - 1))
                        con.clk <= 1'b0;
                    if (half_done && halves == HC_W'(DE_IO_HALVES - 1))
                        con.io <= 1'b0;
                    if (half_done && halves == HC_W'(DE_VCC_HALVES - 1)) begin
                        con.vcc <= 1'b0;
                        state   <= S_IDLE;
                    end
                end
                S_STOP: begin
                    if (!stop_req) state <= S_PUP;
                end
                default: state <= S_PUP;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            S_PUP:                   status_n = 1'b0;
            S_IDLE:                  status_n = pres_ok && !fault_lat;
            S_STOP:                  status_n = card_pres;
            S_ACT, S_ON, S_DEACT:    status_n = !fault_lat;
            default:                 status_n = 1'b0;
        endcase
    end

    assign vcc_en   = con.vcc;
    assign vcc_sel  = con.vcc ? vsel_q : VS_OFF;
    assign io_en    = con.io;
    assign clk_en   = con.clk;
    assign card_rst = con.rst;
endmodule

// File: rtl/cps_card_seq_chk.sv
module cps_card_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       sess_req_n,
    input logic       vcc_en,
    input logic [1:0] vcc_sel,
    input logic       io_en,
    input logic       clk_en,
    input logic       card_rst
);
    AST_IO_NEEDS_VCC: assert property (@(posedge clk) disable iff (rst)
        io_en |-> vcc_en);  // R2

    AST_VCC_ON_BY_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(vcc_en) |-> !$past(sess_req_n));  // R2

    AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (rst)
        clk_en |-> io_en);  // R3

    AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (rst)
        card_rst |-> clk_en);  // R5

    AST_RST_DOWN_BEFORE_CLK: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_en) |-> !card_rst);  // R6

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (vcc_en && $past(vcc_en)) |-> $stable(vcc_sel));  // R11
endmodule

bind cps_card_seq cps_card_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sess_req_n (sess_req_n),
    .vcc_en     (vcc_en),
    .vcc_sel    (vcc_sel),
    .io_en      (io_en),
    .clk_en     (clk_en),
    .card_rst   (card_rst)
);

// File: tb/sim_cps_card_seq.sv
module sim_cps_card_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       sess_req_n, host_rst, sel_18, sel_5v, card_pres, supply_ok;
    logic [2:0] fault_in;
    logic       vcc_en, io_en, clk_en, card_rst, status_n;
    logic [1:0] vcc_sel;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    // Vector layout: {vcc_en, vcc_sel[1:0], io_en, clk_en, card_rst, status_n}
    logic [6:0] outv;
    logic [6:0] prev;
    assign outv = {vcc_en, vcc_sel, io_en, clk_en, card_rst, status_n};

    int         q_c[$];
    logic [6:0] q_v[$];
    string      q_t[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cps_card_seq #(.BASE_TICKS(8), .PUP_TICKS(10), .DEB_TICKS(16), .NFAULT(3)) u0 (
        .clk(clk), .rst(rst), .osc_tick(1'b1), .sess_req_n(sess_req_n),
        .host_rst(host_rst), .sel_18(sel_18), .sel_5v(sel_5v), .card_pres(card_pres),
        .supply_ok(supply_ok), .fault_in(fault_in), .vcc_en(vcc_en), .vcc_sel(vcc_sel),
        .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst), .status_n(status_n)
    );

    task automatic expect_at(input int c, input logic [6:0] v, input string tag);
        q_c.push_back(c);
        q_v.push_back(v);
        q_t.push_back(tag);
    endtask

    task automatic check_now(input logic [6:0] v, input string tag);
        n_chk++;
        if (outv !== v) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, outv, v);
        end
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: every change of the output vector must match the next expectation.
    always @(negedge clk) begin
        if (mon_on && (outv !== prev)) begin
            n_chk++;
            if (q_c.size() == 0) begin
                n_fail++;
                $display("FAIL unpredicted change (R1..R13 scoreboard) at cycle %0d: actual %b expected %b",
                         cyc, outv, prev);
            end else begin
                automatic int         ec = q_c.pop_front();
                automatic logic [6:0] ev = q_v.pop_front();
                automatic string      et = q_t.pop_front();
                if (ec != cyc || ev !== outv) begin
                    n_fail++;
                    $display("FAIL %s: actual cycle %0d vec %b expected cycle %0d vec %b",
                             et, cyc, outv, ec, ev);
                end
            end
            prev = outv;
        end
    end

    always @(posedge clk) begin
        if (!done && cyc > 5000) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
            finish_run();
        end
    end

    initial begin
        int t, t2, s, t3, r, t4, b, f, g;
        rst = 1'b1; sess_req_n = 1'b1; host_rst = 1'b0; sel_18 = 1'b0; sel_5v = 1'b1;
        card_pres = 1'b1; supply_ok = 1'b1; fault_in = 3'b000;
        wait_to(5);
        check_now(7'b0000000, "R1 reset state");
        prev   = outv;
        mon_on = 1'b1;
        rst    = 1'b0;
        // R1/R10: power-up window of 10 then 16 debounce ticks
        expect_at(5 + 26, 7'b0000001, "R10 debounced presence after power-up");
        wait_to(25);
        check_now(7'b0000000, "R1 status low in power-up window");

        // R2 R3 R5 R6 R7: 5 V session, clock starts after I/O
        wait_to(40); t = cyc;
        sess_req_n = 1'b0;
        expect_at(t + 1,  7'b1100001, "R2 R11 supply on with 5V code");
        expect_at(t + 33, 7'b1101001, "R2 io enable at 4T");
        expect_at(t + 34, 7'b1101101, "R3 clock after io");
        expect_at(t + 61, 7'b1101111, "R5 card reset copies host");
        expect_at(t + 67, 7'b1101101, "R5 card reset copies host low");
        expect_at(t + 71, 7'b1101111, "R5 card reset copies host high");
        wait_to(t + 60); host_rst = 1'b1;
        wait_to(t + 66); host_rst = 1'b0;
        wait_to(t + 70); host_rst = 1'b1;
        wait_to(t + 76); t2 = cyc;
        sess_req_n = 1'b1;
        expect_at(t2 + 1,  7'b1101101, "R6 reset low first");
        expect_at(t2 + 5,  7'b1101001, "R6 clock off at T/2");
        expect_at(t2 + 9,  7'b1100001, "R6 io off at T");
        expect_at(t2 + 13, 7'b0000001, "R6 R7 supply off, request ignored");
        expect_at(t2 + 14, 7'b1100001, "R7 activation after idle");
        expect_at(t2 + 46, 7'b1101001, "R2 io enable second session");
        expect_at(t2 + 47, 7'b1101101, "R3 clock second session");
        wait_to(t2 + 2); host_rst = 1'b0;
        wait_to(t2 + 3); sess_req_n = 1'b0;

        // R12: stop requested during a live session
        wait_to(t2 + 80); s = cyc;
        sess_req_n = 1'b1; sel_18 = 1'b1; sel_5v = 1'b1;
        expect_at(s + 5,  7'b1101001, "R12 deactivation finishes: clock");
        expect_at(s + 9,  7'b1100001, "R12 deactivation finishes: io");
        expect_at(s + 13, 7'b0000001, "R12 deactivation finishes: supply");
        expect_at(s + 18, 7'b0000000, "R12 stop status follows absence");
        expect_at(s + 22, 7'b0000001, "R12 stop status follows presence");
        expect_at(s + 27, 7'b0000000, "R12 R1 stop exit power-up window");
        expect_at(s + 53, 7'b0000001, "R12 R10 debounce after stop exit");
        wait_to(s + 16);
        check_now(7'b0000001, "R12 stop state quiet");
        wait_to(s + 18); card_pres = 1'b0;
        wait_to(s + 22); card_pres = 1'b1;
        wait_to(s + 26); sel_5v = 1'b0;
        wait_to(s + 29); sess_req_n = 1'b0;
        wait_to(s + 31);
        check_now(7'b0000000, "R1 request ignored in power-up window");
        wait_to(s + 32); sess_req_n = 1'b1;

        // R4 R9 R11: 1.8 V session, host reset held high to t5, card removed
        wait_to(s + 60); t3 = cyc;
        host_rst = 1'b1; sess_req_n = 1'b0;
        expect_at(t3 + 1,  7'b1110001, "R11 1.8V overrides");
        expect_at(t3 + 33, 7'b1111001, "R2 io enable 1.8V");
        expect_at(t3 + 57, 7'b1111111, "R4 clock and reset at 7T");
        wait_to(t3 + 62); r = cyc;
        card_pres = 1'b0;
        expect_at(r + 1,  7'b1111100, "R9 removal acts at once");
        expect_at(r + 5,  7'b1111000, "R9 R6 clock off");
        expect_at(r + 9,  7'b1110000, "R9 R6 io off");
        expect_at(r + 13, 7'b0000000, "R9 R6 supply off");
        expect_at(r + 36, 7'b0000001, "R10 debounced reinsertion");
        wait_to(r + 2);  host_rst = 1'b0;
        wait_to(r + 16); sess_req_n = 1'b1;
        wait_to(r + 20); card_pres = 1'b1;

        // R4 R8 R11: 3 V session with held clock, then a fault
        wait_to(r + 40); t4 = cyc;
        sel_18 = 1'b0; sel_5v = 1'b0;
        wait_to(t4 + 2); b = cyc;
        host_rst = 1'b1; sess_req_n = 1'b0;
        expect_at(b + 1,  7'b1010001, "R11 3V code");
        expect_at(b + 33, 7'b1011001, "R2 io enable 3V");
        expect_at(b + 41, 7'b1011101, "R4 clock after host reset low");
        wait_to(b + 40); host_rst = 1'b0;
        wait_to(b + 62); f = cyc;
        fault_in = 3'b010;
        expect_at(f + 1,  7'b1011100, "R8 fault drops status");
        expect_at(f + 5,  7'b1011000, "R8 clock off");
        expect_at(f + 9,  7'b1010000, "R8 io off");
        expect_at(f + 13, 7'b0000000, "R8 supply off");
        expect_at(f + 21, 7'b0000001, "R8 status after request withdrawn");
        wait_to(f + 15); fault_in = 3'b000;
        wait_to(f + 19);
        check_now(7'b0000000, "R8 no reactivation while latched");
        wait_to(f + 20); sess_req_n = 1'b1;

        // R13: supply loss during activation
        wait_to(f + 30); g = cyc;
        sel_5v = 1'b1; sess_req_n = 1'b0;
        expect_at(g + 1,  7'b1100001, "R13 session starts");
        expect_at(g + 21, 7'b1100000, "R13 supply loss is a fault");
        expect_at(g + 33, 7'b0000000, "R13 supply off");
        expect_at(g + 70, 7'b0000001, "R13 R1 recovery window then debounce");
        wait_to(g + 20); supply_ok = 1'b0;
        wait_to(g + 40); sess_req_n = 1'b1;
        check_now(7'b0000000, "R13 held in power-up window");
        wait_to(g + 44); supply_ok = 1'b1;

        wait_to(g + 85);
        n_chk++;
        if (q_c.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard R1..R13: actual %0d pending expected 0", q_c.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule